// File: doc/BRIEF.md
# Phase Tick Timebase with Source Watchdog

This block paces the haptic phase timers. It makes a one-cycle tick from one of two sources and divides it by a configurable ratio. The first source is an internal 1 ms time base, which a counter derives from the system clock. The second is an external oscillator pin, which is first resynchronized into the clock domain and reduced to one pulse per rising edge.

Three enable bits set the divide ratio. Each bit switches in one stage of /2, /4 or /16, and the ratio is the product of the enabled stages, so it runs from 1 to 128. Any change of the source select or the enable bits restarts the divider count, so the first tick after a change always comes after a full period.

While the external pin is the source, a watchdog counts clock cycles since the last synchronized rising edge. If that count reaches a limit, it raises a single abort pulse, which lets the phase sequencer stop the motor. The limit is nominally 8 ms, within a 6 to 10 ms window. While the internal source is selected, the watchdog is held idle.

Top module: `phase_tick_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `tick_o` and `abort_o` are low. Reset clears the divider, the time base and the watchdog.
- R2: With `sel_ext`=0 and `div_en`=3'b000 (the default), `tick_o` pulses once every `MS_CYCLES` clock cycles.
- R3: `div_en` bit 0 enables a /2 stage, bit 1 a /4 stage and bit 2 a /16 stage. The tick interval is the source interval times the product of the enabled stages (1 to 128).
- R4: With `sel_ext`=1, each synchronized rising edge of `osc_pin` is one source pulse and the internal base has no effect on `tick_o`.
- R5: `tick_o` is never high in two consecutive cycles.
- R6: A change of `sel_ext` or `div_en` restarts the divider count from zero, so the next tick needs a full new ratio of source pulses.
- R7: With `sel_ext`=1, `abort_o` pulses for one cycle once `WDOG_CYCLES` cycles pass with no synchronized rising edge. It pulses only once per stall.
- R8: With `sel_ext`=0, `abort_o` stays low whatever `osc_pin` does.
- R9: A level held high on `osc_pin` gives exactly one source pulse. Only rising edges count.
- R10: With `sel_ext`=1, rising edges spaced closer than `WDOG_CYCLES` cycles never cause an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_ext | input | 1 | 0: internal 1 ms base, 1: external pin |
| div_en | input | 3 | Stage enables: bit0 /2, bit1 /4, bit2 /16 |
| osc_pin | input | 1 | Raw asynchronous external oscillator pin |
| tick_o | output | 1 | One-cycle phase timer tick |
| abort_o | output | 1 | One-cycle abort pulse on an external source stall |

## Verification
The bench builds the block with `MS_CYCLES`=10 and `WDOG_CYCLES`=40. At these values the full /128 ratio, which is 1280 cycles per tick, fits into a short run, so all eight divider settings are measured as exact intervals. The short watchdog limit lets the bench produce stall timeouts and near-limit edge spacing directly. The external pin is driven by hand, so divider restarts and pulse counts can be checked one edge at a time.

// File: rtl/tick_src_pkg.sv
package tick_src_pkg;

  // Width of the stage-enable field.
  localparam int DIV_EN_W = 3;

  // Width of the divider count (max ratio 128 -> count 0..127).
  localparam int DIV_CNT_W = 7;

  typedef logic [DIV_EN_W-1:0] div_en_t;

  // The enable bits weigh 1, 2 and 4 in the exponent, so the
  // exponent of the ratio is the field read as a binary number.
  function automatic logic [DIV_CNT_W-1:0] ratio_minus1(div_en_t en);
    logic [DIV_CNT_W:0] r;
    r = (DIV_CNT_W + 1)'(1) << en;
    return DIV_CNT_W'(r - (DIV_CNT_W + 1)'(1));
  endfunction

endpackage

// File: rtl/ext_edge_sync.sv
module ext_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic rise
);

  logic [STAGES-1:0] sh;
  logic              last_q;

  // Synchronizer chain: one stage per flop.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[g] <= 1'b0;
          else     sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sh[STAGES-1];
  end

  assign rise = sh[STAGES-1] & ~last_q;

  // A held level gives only one pulse.
  assert_rise_single_R9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/ms_base_gen.sv
module ms_base_gen #(
  parameter int MS_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic base_p
);

  localparam int CW = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MS_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      base_p <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      base_p <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      base_p <= 1'b0;
    end
  end

  assert_base_gap_R2: assert property (@(posedge clk) disable iff (rst)
    base_p |=> !base_p);

endmodule

// File: rtl/src_watchdog.sv
module src_watchdog #(
  parameter int WDOG_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic edge_seen,
  output logic abort_p
);

  localparam int WW = $clog2(WDOG_CYCLES + 1);
  localparam logic [WW-1:0] LIMIT = WW'(WDOG_CYCLES);

  logic [WW-1:0] gap;

  // Count cycles since the last edge; saturate at the limit.
  always_ff @(posedge clk) begin
    if (rst || !armed || edge_seen) gap <= '0;
    else if (gap != LIMIT)          gap <= gap + 1'b1;
  end

  // Fire once, when the count first reaches the limit.
  always_ff @(posedge clk) begin
    if (rst) abort_p <= 1'b0;
    else     abort_p <= armed && !edge_seen && (gap == LIMIT - 1'b1);
  end

  assert_abort_single_R7: assert property (@(posedge clk) disable iff (rst)
    abort_p |=> !abort_p);

  assert_idle_internal_R8: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !abort_p);

  assert_edge_clears_R10: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> !abort_p);

endmodule

// File: rtl/stage_divider.sv
module stage_divider
  import tick_src_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    src_sel,
  input  div_en_t div_en,
  input  logic    src_p,
  output logic    tick
);

  logic [DIV_CNT_W-1:0] cnt;
  logic                 sel_q;
  div_en_t              en_q;
  logic                 cfg_chg;
  logic [DIV_CNT_W-1:0] top;

  assign cfg_chg = (sel_q != src_sel) || (en_q != div_en);
  assign top     = ratio_minus1(en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      en_q  <= '0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      sel_q <= src_sel;
      en_q  <= div_en;
      if (cfg_chg) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (src_p) begin
        if (cnt == top) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end else begin
        tick <= 1'b0;
      end
    end
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= top);

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (cnt == '0) && !tick);

endmodule

// File: rtl/phase_tick_gen.sv
module phase_tick_gen
  import tick_src_pkg::*;
#(
  parameter int MS_CYCLES   = 50000,
  parameter int WDOG_CYCLES = 400000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_ext,
  input  logic [DIV_EN_W-1:0] div_en,
  input  logic                osc_pin,
  output logic                tick_o,
  output logic                abort_o
);

  logic ext_rise;
  logic int_p;
  logic src_p;

  ext_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (osc_pin),
    .rise    (ext_rise)
  );

  ms_base_gen #(.MS_CYCLES(MS_CYCLES)) u_base (
    .clk    (clk),
    .rst    (rst),
    .base_p (int_p)
  );

  assign src_p = sel_ext ? ext_rise : int_p;

  stage_divider u_div (
    .clk     (clk),
    .rst     (rst),
    .src_sel (sel_ext),
    .div_en  (div_en),
    .src_p   (src_p),
    .tick    (tick_o)
  );

  src_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .armed     (sel_ext),
    .edge_seen (ext_rise),
    .abort_p   (abort_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!tick_o && !abort_o));

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  assert_tick_cause_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(src_p));

endmodule

// File: tb/tb_phase_tick_gen.sv
module tb_phase_tick_gen;

  localparam int CLK_PERIOD = 10;
  localparam int MS_C = 10;
  localparam int WD_C = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_ext = 1'b0;
  logic [2:0] div_en = 3'b000;
  logic       osc_pin = 1'b0;
  logic       tick_o;
  logic       abort_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick_cnt = 0;
  int abort_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_tick_gen #(.MS_CYCLES(MS_C), .WDOG_CYCLES(WD_C)) dut (
    .clk(clk), .rst(rst), .sel_ext(sel_ext), .div_en(div_en),
    .osc_pin(osc_pin), .tick_o(tick_o), .abort_o(abort_o)
  );

  always @(negedge clk) begin
    if (tick_o)  tick_cnt++;
    if (abort_o) abort_cnt++;
  end

  // Table: divider enables and the expected tick interval (R3).
  typedef struct packed { logic [2:0] en; int unsigned iv; } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'b000, MS_C*1},   '{3'b001, MS_C*2},
    '{3'b010, MS_C*4},   '{3'b011, MS_C*8},
    '{3'b100, MS_C*16},  '{3'b101, MS_C*32},
    '{3'b110, MS_C*64},  '{3'b111, MS_C*128}
  };

  task automatic check_eq(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!tick_o && cyc < 3000);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulses(int n);
    for (int i = 0; i < n; i++) begin
      osc_pin = 1'b1; idle(3);
      osc_pin = 1'b0; idle(3);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int iv, t0, a0, hi_seen;
    idle(3);
    // R1: outputs quiet during reset
    check_eq(tick_o, 0, "R1 tick in reset");
    check_eq(abort_o, 0, "R1 abort in reset");
    rst = 1'b0;
    hi_seen = 0;
    for (int i = 0; i < MS_C - 2; i++) begin
      @(negedge clk);
      if (tick_o || abort_o) hi_seen++;
    end
    check_eq(hi_seen, 0, "R1 quiet after reset");

    // R2: default interval; R5: one cycle wide
    wait_tick(iv);
    wait_tick(iv);
    check_eq(iv, MS_C, "R2 default period");
    @(negedge clk);
    check_eq(tick_o, 0, "R5 tick width");

    // R3: walk the ratio table
    for (int k = 0; k < 8; k++) begin
      div_en = VECS[k].en;
      wait_tick(iv);
      wait_tick(iv);
      check_eq(iv, int'(VECS[k].iv), $sformatf("R3 ratio en=%0b", VECS[k].en));
    end

    // R8: internal source, pin toggling and stalling, no abort
    div_en = 3'b000;
    a0 = abort_cnt;
    ext_pulses(2);
    idle(100);
    check_eq(abort_cnt - a0, 0, "R8 abort idle on internal");

    // R4: external source ignores internal base
    sel_ext = 1'b1;
    idle(2);
    t0 = tick_cnt;
    idle(30);
    check_eq(tick_cnt - t0, 0, "R4 internal base ignored");
    t0 = tick_cnt;
    ext_pulses(8);
    idle(4);
    check_eq(tick_cnt - t0, 8, "R4 ext ratio 1");
    div_en = 3'b001;
    idle(2);
    t0 = tick_cnt;
    ext_pulses(8);
    idle(4);
    check_eq(tick_cnt - t0, 4, "R4 ext ratio 2");

    // R9: held high level is one edge
    div_en = 3'b000;
    idle(2);
    t0 = tick_cnt;
    osc_pin = 1'b1; idle(20);
    osc_pin = 1'b0; idle(3);
    check_eq(tick_cnt - t0, 1, "R9 level gives one pulse");

    // R6: restart on divider change
    div_en = 3'b010;
    idle(2);
    t0 = tick_cnt;
    ext_pulses(3);
    idle(2);
    check_eq(tick_cnt - t0, 0, "R6 ratio 4 partial");
    div_en = 3'b001;
    idle(2);
    ext_pulses(1);
    idle(2);
    check_eq(tick_cnt - t0, 0, "R6 restart first pulse");
    ext_pulses(1);
    idle(2);
    check_eq(tick_cnt - t0, 1, "R6 restart full ratio");

    // R10: steady edges never abort
    a0 = abort_cnt;
    ext_pulses(20);
    check_eq(abort_cnt - a0, 0, "R10 no abort with edges");

    // R7: stall timeout, once per stall
    idle(30);
    check_eq(abort_cnt - a0, 0, "R7 no abort before limit");
    idle(30);
    check_eq(abort_cnt - a0, 1, "R7 abort after limit");
    idle(60);
    check_eq(abort_cnt - a0, 1, "R7 single abort per stall");
    ext_pulses(1);
    idle(50);
    check_eq(abort_cnt - a0, 2, "R7 re-armed by edge");

    sel_ext = 1'b0;
    idle(5);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule